// File: doc/BRIEF.md
# Inter-core doorbell flag bank

This block carries up to 32 doorbell events from a sending processor to a receiving processor. Each event is one flag bit. The sender raises flags through a write-one set register and can withdraw them through a write-one clear register. The receiver takes events through a write-one acknowledge register. A flag stays raised until one of those two registers removes it. Flag *k* (numbered 1 to 32) sits in data bit *k*-1.

Each side has its own register port, made of a byte address, a write strobe, write data and read data. Read data is combinational from the current address. A write takes effect at the clock edge that samples it.

The sender reads the flag word at one offset and the receiver reads the same word at another. Every flag drives a level interrupt line toward the receiver. A parameter can add one summary interrupt, the OR of the lowest flags.

Top module: `ipc_flag_bank`

## Requirements
- R1: While reset is asserted, and after it, all flags are 0. All interrupt outputs and both read buses read 0 until the first write.
- R2: A sender write to offset 0x00 sets every flag whose data bit is 1 at the next clock edge. Data bits that are 0 leave their flags unchanged.
- R3: A sender write to offset 0x04 clears every flag whose data bit is 1 at the next clock edge. Data bits that are 0 leave their flags unchanged.
- R4: A receiver write to offset 0x10 clears every flag whose data bit is 1 at the next edge. The cleared bit then reads 0 in both the sender view and the receiver view.
- R5: When a set and a clear or acknowledge reach the same bit in the same cycle, the bit ends up 1.
- R6: Offsets 0x00, 0x04 and 0x10 always read 0 on both ports. Any offset outside 0x00, 0x04, 0x08, 0x0C and 0x10 reads 0. A write leaves no stored value behind.
- R7: The sender reads the flag word at offset 0x08 and the receiver reads it at offset 0x0C. Both show the same value, and a write is visible there from the clock edge after it.
- R8: Interrupt line *i* is high exactly while flag bit *i* is 1.
- R9: With the summary enabled, the summary interrupt is the OR of flag bits 0 to SUM_W-1. With it disabled, the summary interrupt is 0.
- R10: A port that writes to an offset owned by the other port changes nothing. The receiver writing 0x00 or 0x04 has no effect, and neither has the sender writing 0x10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snd_addr | input | 5 | Sender byte address |
| snd_we | input | 1 | Sender write strobe |
| snd_wdata | input | NFLAG | Sender write data |
| snd_rdata | output | NFLAG | Sender read data |
| rcv_addr | input | 5 | Receiver byte address |
| rcv_we | input | 1 | Receiver write strobe |
| rcv_wdata | input | NFLAG | Receiver write data |
| rcv_rdata | output | NFLAG | Receiver read data |
| irq | output | NFLAG | Per-flag level interrupts |
| irq_sum | output | 1 | OR of the lowest SUM_W flags |

## Verification
The bench builds the bank at its defaults: NFLAG of 32, SUM_W of 4 and the summary enabled. This puts flag 32 (bit 31) and the summary edge between bits 3 and 4 within reach. It also lets a set from the sender and an acknowledge from the receiver hit the same bit in one cycle, which is the priority case. A random phase mixes owned, foreign and unmapped offsets on both ports against a behavioural model of the flag word.

// File: rtl/ipc_flag_pkg.sv
`timescale 1ns/1ps
package ipc_flag_pkg;
  localparam int unsigned IPC_AW = 5;

  localparam logic [IPC_AW-1:0] OFS_SET  = 5'h00;
  localparam logic [IPC_AW-1:0] OFS_CLR  = 5'h04;
  localparam logic [IPC_AW-1:0] OFS_FLAG = 5'h08;
  localparam logic [IPC_AW-1:0] OFS_STAT = 5'h0C;
  localparam logic [IPC_AW-1:0] OFS_ACK  = 5'h10;

  typedef struct packed {
    logic set_hit;
    logic clr_hit;
    logic ack_hit;
    logic flag_rd;
    logic stat_rd;
  } ipc_dec_t;
endpackage

// File: rtl/ipc_rst_sync.sv
`timescale 1ns/1ps
module ipc_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/ipc_port_dec.sv
`timescale 1ns/1ps
module ipc_port_dec
  import ipc_flag_pkg::*;
#(
  parameter bit OWN_SET  = 1'b0,
  parameter bit OWN_CLR  = 1'b0,
  parameter bit OWN_ACK  = 1'b0,
  parameter bit OWN_FLAG = 1'b0,
  parameter bit OWN_STAT = 1'b0
) (
  input  logic [IPC_AW-1:0] addr,
  input  logic              we,
  output ipc_dec_t          dec
);
  logic set_m, clr_m, ack_m, flag_m, stat_m;

  generate
    if (OWN_SET)  begin : g_set  assign set_m  = we && (addr == OFS_SET);  end
    else          begin : g_nset assign set_m  = 1'b0; end
    if (OWN_CLR)  begin : g_clr  assign clr_m  = we && (addr == OFS_CLR);  end
    else          begin : g_nclr assign clr_m  = 1'b0; end
    if (OWN_ACK)  begin : g_ack  assign ack_m  = we && (addr == OFS_ACK);  end
    else          begin : g_nack assign ack_m  = 1'b0; end
    if (OWN_FLAG) begin : g_flg  assign flag_m = (addr == OFS_FLAG); end
    else          begin : g_nflg assign flag_m = 1'b0; end
    if (OWN_STAT) begin : g_sts  assign stat_m = (addr == OFS_STAT); end
    else          begin : g_nsts assign stat_m = 1'b0; end
  endgenerate

  always_comb begin
    dec         = '0;
    dec.set_hit = set_m;
    dec.clr_hit = clr_m;
    dec.ack_hit = ack_m;
    dec.flag_rd = flag_m;
    dec.stat_rd = stat_m;
  end
endmodule

// File: rtl/ipc_flag_store.sv
`timescale 1ns/1ps
module ipc_flag_store #(
  parameter int unsigned NFLAG = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_v,
  input  logic [NFLAG-1:0] kill_v,
  output logic [NFLAG-1:0] flag_q
);
  logic [NFLAG-1:0] flag_d;
  logic             upd_en;

  // Per-bit next state: a set overrides a clear/ack aimed at the same bit.
  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    always_comb begin
      flag_d[i] = flag_q[i];
      if (kill_v[i]) flag_d[i] = 1'b0;
      if (set_v[i])  flag_d[i] = 1'b1;
    end
  end

  assign upd_en = |(set_v | kill_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= '0;
    else if (upd_en) flag_q <= flag_d;
  end

  // R2 / R5: every bit set in a cycle reads 1 afterwards
  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((flag_q & $past(set_v)) == $past(set_v)));

  // R3 / R4: a clear or ack with no competing set leaves the bit 0
  assert_kill_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(kill_v & ~set_v)) |=> ((flag_q & $past(kill_v & ~set_v)) == '0));

  // R2 / R3: bits not addressed by any strobe keep their value
  assert_untouched_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flag_q ^ $past(flag_q)) & ~$past(set_v | kill_v)) == '0));
endmodule

// File: rtl/ipc_rd_mux.sv
`timescale 1ns/1ps
module ipc_rd_mux
  import ipc_flag_pkg::*;
#(
  parameter int unsigned NFLAG = 32
) (
  input  ipc_dec_t         dec,
  input  logic [NFLAG-1:0] flag_q,
  output logic [NFLAG-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (dec.flag_rd || dec.stat_rd) rdata = flag_q;
  end
endmodule

// File: rtl/ipc_flag_bank.sv
`timescale 1ns/1ps
module ipc_flag_bank
  import ipc_flag_pkg::*;
#(
  parameter int unsigned NFLAG  = 32,
  parameter int unsigned SUM_W  = 4,
  parameter bit          SUM_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IPC_AW-1:0] snd_addr,
  input  logic              snd_we,
  input  logic [NFLAG-1:0]  snd_wdata,
  output logic [NFLAG-1:0]  snd_rdata,
  input  logic [IPC_AW-1:0] rcv_addr,
  input  logic              rcv_we,
  input  logic [NFLAG-1:0]  rcv_wdata,
  output logic [NFLAG-1:0]  rcv_rdata,
  output logic [NFLAG-1:0]  irq,
  output logic              irq_sum
);
  localparam int unsigned SUM_N = (SUM_W > NFLAG) ? NFLAG : SUM_W;

  logic             rst_s_n;
  ipc_dec_t         snd_dec;
  ipc_dec_t         rcv_dec;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] kill_v;
  logic [NFLAG-1:0] flag_q;

  ipc_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_s_n)
  );

  ipc_port_dec #(
    .OWN_SET(1'b1), .OWN_CLR(1'b1), .OWN_ACK(1'b0), .OWN_FLAG(1'b1), .OWN_STAT(1'b0)
  ) u_snd_dec (
    .addr (snd_addr),
    .we   (snd_we),
    .dec  (snd_dec)
  );

  ipc_port_dec #(
    .OWN_SET(1'b0), .OWN_CLR(1'b0), .OWN_ACK(1'b1), .OWN_FLAG(1'b0), .OWN_STAT(1'b1)
  ) u_rcv_dec (
    .addr (rcv_addr),
    .we   (rcv_we),
    .dec  (rcv_dec)
  );

  always_comb begin
    set_v  = snd_dec.set_hit ? snd_wdata : '0;
    kill_v = (snd_dec.clr_hit ? snd_wdata : '0) | (rcv_dec.ack_hit ? rcv_wdata : '0);
  end

  ipc_flag_store #(.NFLAG(NFLAG)) u_store (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .set_v  (set_v),
    .kill_v (kill_v),
    .flag_q (flag_q)
  );

  ipc_rd_mux #(.NFLAG(NFLAG)) u_snd_rd (
    .dec    (snd_dec),
    .flag_q (flag_q),
    .rdata  (snd_rdata)
  );

  ipc_rd_mux #(.NFLAG(NFLAG)) u_rcv_rd (
    .dec    (rcv_dec),
    .flag_q (flag_q),
    .rdata  (rcv_rdata)
  );

  assign irq = flag_q;

  generate
    if (SUM_EN) begin : g_sum
      assign irq_sum = |flag_q[SUM_N-1:0];
    end else begin : g_nosum
      assign irq_sum = 1'b0;
    end
  endgenerate

  // R6: strobe-only offsets never return data on either port
  assert_ack_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rcv_addr == OFS_ACK || snd_addr == OFS_ACK) |->
      ((rcv_addr != OFS_ACK || rcv_rdata == '0) && (snd_addr != OFS_ACK || snd_rdata == '0)));

  // R7: sender flag view and receiver status view agree
  assert_views_match_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (snd_addr == OFS_FLAG && rcv_addr == OFS_STAT) |-> (snd_rdata == rcv_rdata));

  // R10: a receiver write to the set offset raises nothing by itself
  assert_foreign_set_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rcv_we && rcv_addr == OFS_SET && !(snd_we && snd_addr == OFS_SET))
      |=> ((irq & ~$past(irq)) == '0));
endmodule

// File: tb/ipc_flag_bank_bench.sv
`timescale 1ns/1ps
module ipc_flag_bank_bench;
  localparam int NF = 32;

  logic          clk;
  logic          rst_n;
  logic [4:0]    snd_addr, rcv_addr;
  logic          snd_we, rcv_we;
  logic [NF-1:0] snd_wdata, rcv_wdata, snd_rdata, rcv_rdata, irq;
  logic          irq_sum;

  int            total;
  int            bad;
  bit            done;
  logic [NF-1:0] model;

  ipc_flag_bank u_ipc_flag_bank (
    .clk(clk), .rst_n(rst_n),
    .snd_addr(snd_addr), .snd_we(snd_we), .snd_wdata(snd_wdata), .snd_rdata(snd_rdata),
    .rcv_addr(rcv_addr), .rcv_we(rcv_we), .rcv_wdata(rcv_wdata), .rcv_rdata(rcv_rdata),
    .irq(irq), .irq_sum(irq_sum)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [NF-1:0] act, input logic [NF-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [NF-1:0] es, er;
    es = (snd_addr == 5'h08) ? model : '0;
    er = (rcv_addr == 5'h0C) ? model : '0;
    chk({tag, " snd_rdata"}, snd_rdata, es);
    chk({tag, " rcv_rdata"}, rcv_rdata, er);
    chk("R8 irq", irq, model);
    chk("R9 irq_sum", {{(NF-1){1'b0}}, irq_sum}, {{(NF-1){1'b0}}, |model[3:0]});
  endtask

  task automatic step(input logic [4:0] sa, input logic swe, input logic [NF-1:0] sd,
                      input logic [4:0] ra, input logic rwe, input logic [NF-1:0] rd,
                      input string tag);
    logic [NF-1:0] s, k;
    snd_addr = sa; snd_we = swe; snd_wdata = sd;
    rcv_addr = ra; rcv_we = rwe; rcv_wdata = rd;
    @(posedge clk);
    s = (swe && sa == 5'h00) ? sd : '0;
    k = ((swe && sa == 5'h04) ? sd : '0) | ((rwe && ra == 5'h10) ? rd : '0);
    model = (model & ~k) | s;
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    int cyc;
    for (cyc = 0; cyc < 20000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 1'b0; model = '0;
    rst_n = 1'b0;
    snd_addr = 5'h08; snd_we = 1'b0; snd_wdata = '0;
    rcv_addr = 5'h0C; rcv_we = 1'b0; rcv_wdata = '0;
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(5'h08, 1'b0, '0, 5'h0C, 1'b0, '0, "R1 after reset");

    // R2: set, including a zero write and the top flag
    step(5'h00, 1'b1, 32'h0000_0001, 5'h0C, 1'b0, '0, "R2 set bit0");
    step(5'h08, 1'b0, '0, 5'h0C, 1'b0, '0, "R7 views after set");
    step(5'h00, 1'b1, 32'h0000_0000, 5'h0C, 1'b0, '0, "R2 zero write");
    step(5'h00, 1'b1, 32'h8000_0000, 5'h0C, 1'b0, '0, "R2 set bit31");
    step(5'h08, 1'b0, '0, 5'h0C, 1'b0, '0, "R7 views bit31");
    step(5'h00, 1'b1, 32'h0000_0010, 5'h0C, 1'b0, '0, "R9 bit4 outside sum");
    step(5'h00, 1'b1, 32'h0000_000E, 5'h0C, 1'b0, '0, "R9 sum bits");
    // R3: clear
    step(5'h04, 1'b1, 32'h0000_0002, 5'h0C, 1'b0, '0, "R3 clear bit1");
    step(5'h04, 1'b1, 32'h0000_0000, 5'h0C, 1'b0, '0, "R3 zero clear");
    step(5'h08, 1'b0, '0, 5'h0C, 1'b0, '0, "R3 after clear");
    // R4: acknowledge from receiver
    step(5'h08, 1'b0, '0, 5'h10, 1'b1, 32'h8000_0000, "R4 ack bit31");
    step(5'h08, 1'b0, '0, 5'h0C, 1'b0, '0, "R4 both views");
    // R5: same-cycle conflicts
    step(5'h00, 1'b1, 32'h0000_0100, 5'h10, 1'b1, 32'h0000_0100, "R5 set vs ack");
    step(5'h08, 1'b0, '0, 5'h0C, 1'b0, '0, "R5 result");
    step(5'h00, 1'b1, 32'h0000_0010, 5'h10, 1'b1, 32'h0000_0011, "R5 set vs ack mix");
    // R6: zero readback
    step(5'h00, 1'b0, '0, 5'h10, 1'b0, '0, "R6 set/ack offsets");
    step(5'h04, 1'b0, '0, 5'h00, 1'b0, '0, "R6 clr/set offsets");
    step(5'h10, 1'b0, '0, 5'h04, 1'b0, '0, "R6 ack on sender");
    step(5'h14, 1'b0, '0, 5'h1C, 1'b0, '0, "R6 unmapped");
    step(5'h0C, 1'b0, '0, 5'h08, 1'b0, '0, "R6 foreign views");
    step(5'h02, 1'b0, '0, 5'h0E, 1'b0, '0, "R6 misaligned");
    // R10: foreign-offset writes ignored
    step(5'h08, 1'b0, '0, 5'h00, 1'b1, 32'hFFFF_FFFF, "R10 rcv writes set");
    step(5'h08, 1'b0, '0, 5'h04, 1'b1, 32'hFFFF_FFFF, "R10 rcv writes clr");
    step(5'h10, 1'b1, 32'hFFFF_FFFF, 5'h0C, 1'b0, '0, "R10 snd writes ack");
    step(5'h08, 1'b0, '0, 5'h0C, 1'b0, '0, "R10 state kept");
    // R8/R9: ack everything
    step(5'h08, 1'b0, '0, 5'h10, 1'b1, 32'hFFFF_FFFF, "R8 ack all");
    step(5'h08, 1'b0, '0, 5'h0C, 1'b0, '0, "R9 all low");
    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      logic [4:0] tbl [6];
      tbl = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14};
      step(tbl[$urandom_range(0, 5)], 1'($urandom), 32'($urandom) & 32'($urandom),
           tbl[$urandom_range(0, 5)], 1'($urandom), 32'($urandom) | 32'($urandom),
           "R7 random");
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule